// File: doc/BRIEF.md
# Precise Pipeline Trap Controller

This block sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It turns faults detected in any stage into precise traps. Each instruction that enters the pipeline gets a small status word: a valid bit, a delay-slot bit, a cause code and the tag of the stage that raised it. That word travels down the pipeline together with the instruction's PC. A stage adds its own fault to the word only when the word holds no fault yet. A fault found early therefore always wins over one found later for the same instruction.

The block does not act on a fault when it is detected. It acts when the carrying instruction reaches the commit point, which is the memory/writeback boundary. In that cycle it flushes every stage from fetch to memory, blocks the data-memory write and redirects fetch to a fixed trap vector. In the next cycle it blocks the register-file write of the faulting instruction. It also saves the faulting PC, the cause and the stage tag. When the instruction sat in a branch delay slot, the branch PC is saved as well and becomes the restart address.

A sticky pending flag holds the saved state and blocks further traps until the handler pulses the return strobe. Integer overflow can be masked, in which case it is never recorded.

Top module: `precise_trap_ctrl`

## Requirements
- R1: After reset, trap_o, flush_o, dm_we_block_o, rf_we_block_o, pending_o, in_slot_o and cause_o are all 0, and epc_o is 0.
- R2: An instruction presented at fetch in cycle c that carries a fault raises trap_o in cycle c+3, when it occupies the memory stage. In that same cycle flush_o is 4'b1111 (bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory) and trap_pc_o equals the TRAP_VEC parameter. No trap is raised in any other cycle.
- R3: Traps are taken in program order. An older instruction's memory-stage or execute-stage fault is taken in preference to a younger instruction's fault that was detected earlier in time.
- R4: Cause codes are 1 fetch page fault, 2 fetch misaligned, 3 fetch protection, 4 illegal opcode, 5 overflow, 6 memory page fault, 7 memory misaligned or protection. Within one instruction the fault of the earliest stage is kept, and within fetch the order is page fault, then misaligned, then protection. Within memory a page fault comes before the other two. cause_stage_o reports 0 for fetch, 1 for decode, 2 for execute and 3 for memory.
- R5: While ovf_mask_i is 1, an execute-stage overflow is dropped. The instruction then traps only on a later memory fault, or not at all.
- R6: dm_we_block_o is 1 exactly in the trap cycle. rf_we_block_o is 1 exactly in the cycle after it.
- R7: From the cycle after a trap, epc_o holds the faulting PC and cause_o and cause_stage_o hold its cause. For a fault outside a delay slot, restart_pc_o equals epc_o. These values stay unchanged while pending_o is 1.
- R8: For a fault on an instruction whose delay-slot flag was 1 at fetch, in_slot_o is 1 and branch_pc_o equals epc_o minus INSN_B (4). restart_pc_o then equals branch_pc_o.
- R9: pending_o rises the cycle after a trap. While it is 1, no further trap is taken. It falls in the cycle after trap_ret_i is sampled high.
- R10: Instructions flushed by a trap, and fetch slots with if_valid_i low, never cause a trap. A program with no faults causes none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_valid_i | input | 1 | Fetch stage holds a real instruction |
| if_pc_i | input | PC_W | PC of the instruction in fetch |
| if_bds_i | input | 1 | Instruction in fetch is a branch delay slot |
| if_page_flt_i | input | 1 | Fetch page fault |
| if_misalign_i | input | 1 | Fetch misaligned access |
| if_prot_i | input | 1 | Fetch protection violation |
| id_illegal_i | input | 1 | Decode found an illegal or undefined opcode |
| ex_ovf_i | input | 1 | Execute arithmetic overflow |
| ovf_mask_i | input | 1 | Overflow is masked by the user |
| mem_page_flt_i | input | 1 | Memory-stage page fault |
| mem_misalign_i | input | 1 | Memory-stage misaligned access |
| mem_prot_i | input | 1 | Memory-stage protection violation |
| trap_ret_i | input | 1 | Handler return, clears pending |
| flush_o | output | 4 | Per-stage flush, bit 0 fetch to bit 3 memory |
| trap_o | output | 1 | Trap taken this cycle, redirect fetch |
| trap_pc_o | output | PC_W | Fetch redirect target (trap vector) |
| dm_we_block_o | output | 1 | Inhibit the data-memory write |
| rf_we_block_o | output | 1 | Inhibit the register-file write |
| epc_o | output | PC_W | Saved PC of the faulting instruction |
| branch_pc_o | output | PC_W | Saved branch PC for a delay-slot fault |
| in_slot_o | output | 1 | Saved fault was in a delay slot |
| restart_pc_o | output | PC_W | Address at which to resume |
| cause_o | output | 3 | Saved cause code |
| cause_stage_o | output | 2 | Saved stage tag |
| pending_o | output | 1 | Trap pending, handler active |

## Verification
trap_o, flush_o, trap_pc_o and dm_we_block_o are due in the third cycle after the faulting instruction was presented at fetch. rf_we_block_o, pending_o and the saved PC, cause and stage are due one cycle later. The clearing of pending_o is due one cycle after trap_ret_i is sampled. The driver stamps each expected trap with its due cycle, taken from a free-running cycle count, and pushes it into a queue. The monitor samples on the falling edge. It reports any trap that arrives in a cycle other than the one stamped, checks the saved state exactly one cycle after each trap, and flags any expected trap whose cycle has passed without it.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [2:0] {
    C_NONE     = 3'd0,
    C_IF_PAGE  = 3'd1,
    C_IF_MIS   = 3'd2,
    C_IF_PROT  = 3'd3,
    C_ILLEGAL  = 3'd4,
    C_OVF      = 3'd5,
    C_MEM_PAGE = 3'd6,
    C_MEM_ACC  = 3'd7
  } cause_e;

  typedef enum logic [1:0] {
    ST_IF  = 2'd0,
    ST_ID  = 2'd1,
    ST_EX  = 2'd2,
    ST_MEM = 2'd3
  } stage_e;

  typedef struct packed {
    logic   valid;
    logic   bds;
    cause_e cause;
    stage_e tag;
  } exc_tag_t;

  localparam exc_tag_t EXC_IDLE = '{valid: 1'b0, bds: 1'b0, cause: C_NONE, tag: ST_IF};
endpackage

// File: rtl/ptc_cause_encode.sv
module ptc_cause_encode
  import ptc_pkg::*;
(
  input  logic     if_valid_i,
  input  logic     if_bds_i,
  input  logic     if_page_flt_i,
  input  logic     if_misalign_i,
  input  logic     if_prot_i,
  input  logic     id_illegal_i,
  input  logic     ex_ovf_i,
  input  logic     ovf_mask_i,
  input  logic     mem_page_flt_i,
  input  logic     mem_misalign_i,
  input  logic     mem_prot_i,
  output exc_tag_t if_word_o,
  output cause_e   id_raise_o,
  output cause_e   ex_raise_o,
  output cause_e   mem_raise_o
);
  always_comb begin
    if_word_o.valid = if_valid_i;
    if_word_o.bds   = if_bds_i;
    if_word_o.tag   = ST_IF;
    if (!if_valid_i)        if_word_o.cause = C_NONE;
    else if (if_page_flt_i) if_word_o.cause = C_IF_PAGE;
    else if (if_misalign_i) if_word_o.cause = C_IF_MIS;
    else if (if_prot_i)     if_word_o.cause = C_IF_PROT;
    else                    if_word_o.cause = C_NONE;
  end

  assign id_raise_o = id_illegal_i ? C_ILLEGAL : C_NONE;
  // masked overflow is dropped, never recorded
  assign ex_raise_o = (ex_ovf_i && !ovf_mask_i) ? C_OVF : C_NONE;

  always_comb begin
    if (mem_page_flt_i)                  mem_raise_o = C_MEM_PAGE;
    else if (mem_misalign_i || mem_prot_i) mem_raise_o = C_MEM_ACC;
    else                                 mem_raise_o = C_NONE;
  end
endmodule

// File: rtl/ptc_stage_slot.sv
module ptc_stage_slot
  import ptc_pkg::*;
#(
  parameter int     PC_W = 32,
  parameter stage_e TAG  = ST_ID
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  exc_tag_t        word_i,
  input  logic [PC_W-1:0] pc_i,
  input  cause_e          raise_i,
  output exc_tag_t        word_o,
  output logic [PC_W-1:0] pc_o
);
  exc_tag_t        word_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= EXC_IDLE;
      pc_q   <= '0;
    end else begin
      word_q <= flush_i ? EXC_IDLE : word_i;
      pc_q   <= pc_i;
    end
  end

  // first fault per instruction is kept
  always_comb begin
    word_o = word_q;
    if (word_q.valid && word_q.cause == C_NONE && raise_i != C_NONE) begin
      word_o.cause = raise_i;
      word_o.tag   = TAG;
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/ptc_commit.sv
module ptc_commit
  import ptc_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int INSN_B = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  exc_tag_t        word_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            ret_i,
  output logic            take_o,
  output logic            rf_block_o,
  output logic            pending_o,
  output logic [PC_W-1:0] epc_o,
  output logic [PC_W-1:0] bpc_o,
  output logic            bds_o,
  output cause_e          cause_o,
  output stage_e          stage_o,
  output logic [PC_W-1:0] restart_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_B);

  logic            pend_q, rf_q, bds_q;
  logic [PC_W-1:0] epc_q, bpc_q;
  cause_e          cause_q;
  stage_e          stage_q;

  assign take_o = word_i.valid && (word_i.cause != C_NONE) && !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      rf_q    <= 1'b0;
      bds_q   <= 1'b0;
      epc_q   <= '0;
      bpc_q   <= '0;
      cause_q <= C_NONE;
      stage_q <= ST_IF;
    end else begin
      rf_q <= take_o;
      if (take_o) begin
        pend_q  <= 1'b1;
        epc_q   <= pc_i;
        bpc_q   <= word_i.bds ? pc_i - STEP : pc_i;
        bds_q   <= word_i.bds;
        cause_q <= word_i.cause;
        stage_q <= word_i.tag;
      end else if (ret_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign rf_block_o = rf_q;
  assign pending_o  = pend_q;
  assign epc_o      = epc_q;
  assign bpc_o      = bpc_q;
  assign bds_o      = bds_q;
  assign cause_o    = cause_q;
  assign stage_o    = stage_q;
  assign restart_o  = bds_q ? bpc_q : epc_q;
endmodule

// File: rtl/precise_trap_ctrl.sv
module precise_trap_ctrl
  import ptc_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              INSN_B   = 4,
  parameter logic [PC_W-1:0] TRAP_VEC = PC_W'(32'h0000_0080)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            if_valid_i,
  input  logic [PC_W-1:0] if_pc_i,
  input  logic            if_bds_i,
  input  logic            if_page_flt_i,
  input  logic            if_misalign_i,
  input  logic            if_prot_i,
  input  logic            id_illegal_i,
  input  logic            ex_ovf_i,
  input  logic            ovf_mask_i,
  input  logic            mem_page_flt_i,
  input  logic            mem_misalign_i,
  input  logic            mem_prot_i,
  input  logic            trap_ret_i,
  output logic [3:0]      flush_o,
  output logic            trap_o,
  output logic [PC_W-1:0] trap_pc_o,
  output logic            dm_we_block_o,
  output logic            rf_we_block_o,
  output logic [PC_W-1:0] epc_o,
  output logic [PC_W-1:0] branch_pc_o,
  output logic            in_slot_o,
  output logic [PC_W-1:0] restart_pc_o,
  output logic [2:0]      cause_o,
  output logic [1:0]      cause_stage_o,
  output logic            pending_o
);
  localparam int NSLOT = 3;

  exc_tag_t        word_c  [0:NSLOT];
  logic [PC_W-1:0] pc_c    [0:NSLOT];
  cause_e          raise_c [1:NSLOT];
  cause_e          id_raise, ex_raise, mem_raise;
  cause_e          cause_q;
  stage_e          stage_q;
  logic            take;

  ptc_cause_encode u_enc (
    .if_valid_i     (if_valid_i),
    .if_bds_i       (if_bds_i),
    .if_page_flt_i  (if_page_flt_i),
    .if_misalign_i  (if_misalign_i),
    .if_prot_i      (if_prot_i),
    .id_illegal_i   (id_illegal_i),
    .ex_ovf_i       (ex_ovf_i),
    .ovf_mask_i     (ovf_mask_i),
    .mem_page_flt_i (mem_page_flt_i),
    .mem_misalign_i (mem_misalign_i),
    .mem_prot_i     (mem_prot_i),
    .if_word_o      (word_c[0]),
    .id_raise_o     (id_raise),
    .ex_raise_o     (ex_raise),
    .mem_raise_o    (mem_raise)
  );

  assign pc_c[0]    = if_pc_i;
  assign raise_c[1] = id_raise;
  assign raise_c[2] = ex_raise;
  assign raise_c[3] = mem_raise;

  for (genvar g = 1; g <= NSLOT; g++) begin : g_slot
    ptc_stage_slot #(
      .PC_W (PC_W),
      .TAG  (stage_e'(g))
    ) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (take),
      .word_i  (word_c[g-1]),
      .pc_i    (pc_c[g-1]),
      .raise_i (raise_c[g]),
      .word_o  (word_c[g]),
      .pc_o    (pc_c[g])
    );
  end

  ptc_commit #(
    .PC_W   (PC_W),
    .INSN_B (INSN_B)
  ) u_commit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (word_c[NSLOT]),
    .pc_i       (pc_c[NSLOT]),
    .ret_i      (trap_ret_i),
    .take_o     (take),
    .rf_block_o (rf_we_block_o),
    .pending_o  (pending_o),
    .epc_o      (epc_o),
    .bpc_o      (branch_pc_o),
    .bds_o      (in_slot_o),
    .cause_o    (cause_q),
    .stage_o    (stage_q),
    .restart_o  (restart_pc_o)
  );

  assign trap_o        = take;
  assign flush_o       = {(NSLOT + 1){take}};
  assign trap_pc_o     = TRAP_VEC;
  assign dm_we_block_o = take;
  assign cause_o       = cause_q;
  assign cause_stage_o = stage_q;
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] TRAP_VEC = '0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            trap_ret_i,
  input logic [3:0]      flush_o,
  input logic            trap_o,
  input logic [PC_W-1:0] trap_pc_o,
  input logic            dm_we_block_o,
  input logic            rf_we_block_o,
  input logic [PC_W-1:0] epc_o,
  input logic [PC_W-1:0] branch_pc_o,
  input logic            in_slot_o,
  input logic [PC_W-1:0] restart_pc_o,
  input logic [2:0]      cause_o,
  input logic [1:0]      cause_stage_o,
  input logic            pending_o
);
  p_flush_all_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> flush_o == 4'b1111);
  p_vector_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> trap_pc_o == TRAP_VEC);
  p_dm_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> dm_we_block_o);
  p_rf_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> rf_we_block_o);
  p_rf_only_after_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_block_o |-> $past(trap_o));
  p_pend_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> pending_o);
  p_no_second_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o |-> !trap_o);
  p_pend_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && trap_ret_i |=> !pending_o);
  p_cause_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> cause_o != 3'd0);
  p_slot_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && in_slot_o |-> restart_pc_o == branch_pc_o);
  p_plain_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && !in_slot_o |-> restart_pc_o == epc_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && $past(pending_o) |-> $stable(epc_o) && $stable(cause_o));
  p_fetch_tag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && cause_o inside {3'd1, 3'd2, 3'd3} |-> cause_stage_o == 2'd0);
endmodule

bind precise_trap_ctrl ptc_checker #(
  .PC_W     (PC_W),
  .TRAP_VEC (TRAP_VEC)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .trap_ret_i    (trap_ret_i),
  .flush_o       (flush_o),
  .trap_o        (trap_o),
  .trap_pc_o     (trap_pc_o),
  .dm_we_block_o (dm_we_block_o),
  .rf_we_block_o (rf_we_block_o),
  .epc_o         (epc_o),
  .branch_pc_o   (branch_pc_o),
  .in_slot_o     (in_slot_o),
  .restart_pc_o  (restart_pc_o),
  .cause_o       (cause_o),
  .cause_stage_o (cause_stage_o),
  .pending_o     (pending_o)
);

// File: tb/precise_trap_ctrl_tb.sv
`timescale 1ns/1ps
module precise_trap_ctrl_tb;
  localparam logic [31:0] VEC = 32'h0000_0080;
  localparam logic [7:0] F_IPG = 8'h01, F_IMIS = 8'h02, F_IPROT = 8'h04, F_ILL = 8'h08,
                         F_OVF = 8'h10, F_MPG = 8'h20, F_MMIS = 8'h40, F_MPROT = 8'h80;

  logic        clk_i = 0, rst_ni = 0;
  logic        if_valid_i, if_bds_i, if_page_flt_i, if_misalign_i, if_prot_i;
  logic [31:0] if_pc_i;
  logic        id_illegal_i, ex_ovf_i, ovf_mask_i;
  logic        mem_page_flt_i, mem_misalign_i, mem_prot_i, trap_ret_i;
  logic [3:0]  flush_o;
  logic        trap_o, dm_we_block_o, rf_we_block_o, in_slot_o, pending_o;
  logic [31:0] trap_pc_o, epc_o, branch_pc_o, restart_pc_o;
  logic [2:0]  cause_o;
  logic [1:0]  cause_stage_o;

  precise_trap_ctrl #(.PC_W(32), .INSN_B(4), .TRAP_VEC(VEC)) u_dut (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {logic [31:0] pc; bit bds; logic [7:0] f;} ins_t;
  typedef struct {int cyc; logic [2:0] cause; logic [1:0] stg; logic [31:0] pc; bit bds;} exp_t;

  ins_t prog[8];
  int   prog_n;
  exp_t exq[$];
  exp_t cur;
  bit   post_chk = 0;
  bit   done = 0;
  int   cyc = 0, checks = 0, errors = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [2:0] exp_cause(ins_t x, bit m);
    if (x.f[0]) return 3'd1;
    if (x.f[1]) return 3'd2;
    if (x.f[2]) return 3'd3;
    if (x.f[3]) return 3'd4;
    if (x.f[4] && !m) return 3'd5;
    if (x.f[5]) return 3'd6;
    if (x.f[6] || x.f[7]) return 3'd7;
    return 3'd0;
  endfunction

  function automatic logic [1:0] exp_stage(logic [2:0] c);
    if (c <= 3'd3) return 2'd0;
    if (c == 3'd4) return 2'd1;
    if (c == 3'd5) return 2'd2;
    return 2'd3;
  endfunction

  task automatic idle();
    if_valid_i = 0; if_pc_i = 0; if_bds_i = 0; if_page_flt_i = 0; if_misalign_i = 0;
    if_prot_i = 0; id_illegal_i = 0; ex_ovf_i = 0; mem_page_flt_i = 0;
    mem_misalign_i = 0; mem_prot_i = 0; trap_ret_i = 0;
  endtask

  task automatic add(input logic [31:0] pc, input bit bds, input logic [7:0] f);
    prog[prog_n] = '{pc: pc, bds: bds, f: f};
    prog_n++;
  endtask

  // driver: feeds the program, pushes the expected trap with its due cycle
  task automatic run(input bit mask, input bit blocked);
    int w = -1;
    exp_t e;
    for (int i = 0; i < prog_n; i++)
      if (w < 0 && exp_cause(prog[i], mask) != 0) w = i;
    for (int t = 0; t < prog_n + 4; t++) begin
      @(posedge clk_i); #1;
      if (t == 0 && w >= 0 && !blocked) begin
        e.cyc = cyc + w + 3; e.cause = exp_cause(prog[w], mask);
        e.stg = exp_stage(e.cause); e.pc = prog[w].pc; e.bds = prog[w].bds;
        exq.push_back(e);
      end
      ovf_mask_i = mask;
      if_valid_i = (t < prog_n) && (w < 0 || blocked || t <= w + 3);
      if_pc_i = (t < prog_n) ? prog[t].pc : 32'h0;
      if_bds_i = (t < prog_n) ? prog[t].bds : 1'b0;
      if_page_flt_i = (t < prog_n) ? prog[t].f[0] : 1'b0;
      if_misalign_i = (t < prog_n) ? prog[t].f[1] : 1'b0;
      if_prot_i = (t < prog_n) ? prog[t].f[2] : 1'b0;
      id_illegal_i = (t >= 1 && t - 1 < prog_n) ? prog[t-1].f[3] : 1'b0;
      ex_ovf_i = (t >= 2 && t - 2 < prog_n) ? prog[t-2].f[4] : 1'b0;
      mem_page_flt_i = (t >= 3 && t - 3 < prog_n) ? prog[t-3].f[5] : 1'b0;
      mem_misalign_i = (t >= 3 && t - 3 < prog_n) ? prog[t-3].f[6] : 1'b0;
      mem_prot_i = (t >= 3 && t - 3 < prog_n) ? prog[t-3].f[7] : 1'b0;
    end
    @(posedge clk_i); #1;
    idle();
    ovf_mask_i = mask;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R2", "expected traps outstanding", exq.size(), 0);
    prog_n = 0;
  endtask

  task automatic do_ret();
    @(posedge clk_i); #1 trap_ret_i = 1;
    @(posedge clk_i); #1 trap_ret_i = 0;
    @(negedge clk_i);
    chk("R9", "pending after return", pending_o, 0);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (post_chk) begin
        post_chk = 0;
        chk("R6", "rf block after trap", rf_we_block_o, 1);
        chk("R9", "pending after trap", pending_o, 1);
        chk("R7", "saved pc", epc_o, cur.pc);
        chk("R4", "cause", cause_o, cur.cause);
        chk("R4", "stage tag", cause_stage_o, cur.stg);
        chk("R8", "slot flag", in_slot_o, cur.bds);
        if (cur.bds) begin
          chk("R8", "branch pc", branch_pc_o, cur.pc - 32'd4);
          chk("R8", "restart pc", restart_pc_o, cur.pc - 32'd4);
        end else begin
          chk("R7", "restart pc", restart_pc_o, cur.pc);
        end
      end else begin
        chk("R6", "rf block idle", rf_we_block_o, 0);
      end
      if (exq.size() > 0 && exq[0].cyc < cyc) begin
        chk("R2", "missed trap cycle", 32'(cyc), 32'(exq[0].cyc));
        void'(exq.pop_front());
      end
      if (trap_o) begin
        if (exq.size() == 0 || exq[0].cyc != cyc) begin
          chk("R10", "unexpected trap", 1, 0);
        end else begin
          cur = exq.pop_front();
          chk("R2", "flush", flush_o, 4'b1111);
          chk("R2", "redirect", trap_pc_o, VEC);
          chk("R6", "dm block", dm_we_block_o, 1);
          post_chk = 1;
        end
      end else begin
        chk("R6", "dm block idle", dm_we_block_o, 0);
      end
    end
  end

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      finish_up();
    end
  end

  initial begin
    logic [31:0] saved;
    prog_n = 0;
    idle();
    ovf_mask_i = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    chk("R1", "trap", trap_o, 0);
    chk("R1", "flush", flush_o, 0);
    chk("R1", "pending", pending_o, 0);
    chk("R1", "cause", cause_o, 0);
    chk("R1", "epc", epc_o, 0);
    chk("R1", "slot", in_slot_o, 0);

    // R10: clean program, no trap
    add(32'h100, 0, 0); add(32'h104, 0, 0); add(32'h108, 0, 0);
    run(0, 0);

    // R2/R4: fetch page fault on third instruction
    add(32'h100, 0, 0); add(32'h104, 0, 0); add(32'h108, 0, F_IPG); add(32'h10c, 0, 0);
    run(0, 0); do_ret();

    // R4: fetch priority misaligned over protection
    add(32'h200, 0, F_IMIS | F_IPROT); run(0, 0); do_ret();
    add(32'h204, 0, F_IPROT); run(0, 0); do_ret();
    // R4: decode before memory on one instruction
    add(32'h208, 0, F_ILL | F_MPG); run(0, 0); do_ret();
    // R4: memory page fault over misaligned; misaligned/protection share code 7
    add(32'h20c, 0, F_MPG | F_MMIS); run(0, 0); do_ret();
    add(32'h210, 0, F_MPROT); run(0, 0); do_ret();

    // R3: older memory fault beats younger fetch fault
    add(32'h300, 0, F_MPG); add(32'h304, 0, F_IPG); run(0, 0); do_ret();
    // R3: older overflow beats younger illegal opcode
    add(32'h310, 0, F_OVF); add(32'h314, 0, F_ILL); run(0, 0); do_ret();

    // R10: flushed younger memory fault is never taken
    add(32'h320, 0, F_ILL); add(32'h324, 0, F_MPG); add(32'h328, 0, F_MMIS); run(0, 0); do_ret();

    // R5: masked overflow dropped; memory fault then taken
    add(32'h400, 0, F_OVF); add(32'h404, 0, 0); run(1, 0);
    add(32'h408, 0, F_OVF | F_MPROT); run(1, 0); do_ret();
    add(32'h40c, 0, F_OVF); run(0, 0); do_ret();

    // R8: fault in delay slot
    add(32'h500, 0, 0); add(32'h504, 1, F_ILL); run(0, 0); do_ret();
    add(32'h600, 0, 0); add(32'h604, 1, F_MPG); run(0, 0);

    // R9: pending blocks a second trap, state held
    saved = epc_o;
    add(32'h700, 0, F_IPG); run(0, 1);
    @(negedge clk_i);
    chk("R9", "pending held", pending_o, 1);
    chk("R7", "saved pc held", epc_o, saved);
    do_ret();
    add(32'h704, 0, F_IPG); run(0, 0); do_ret();

    done = 1;
    finish_up();
  end
endmodule